// File: doc/BRIEF.md
# Per-Block Read Voltage Calibration Engine

This engine runs in the background and keeps, for every block of a flash array, one starting read reference voltage that tracks slow charge loss. When a trigger arrives, normally about once a day, it visits the blocks one after another. For each block it reads the stored voltage from an external table. It then sends test reads of the last page of the block, the page with the shortest retention age, and gets an error count back for each read. It keeps the voltage code that produced the fewest errors and writes it back to the table before moving to the next block.

The search for one block starts at the stored code. It steps one code lower at a time while the error count keeps falling. After that it steps one code higher at a time, starting from the best code found so far, again only while the count keeps falling. Voltage codes are 8 bits wide and saturate at both ends. A step that gives an equal count does not replace the code already held.

Test reads leave the engine on a valid/ready request stream, with one read in flight at a time. Error counts come back on a valid/ready response stream. The flash access and the error counting sit outside the block. The table has a combinational read port addressed by the engine and a one-cycle write strobe.

Top module: `rdv_calib_engine`

## Requirements
- R1: After reset, `busy` is 0. A `trigger` sampled high while `busy` is 0 makes `busy` 1 from the next clock edge. `busy` stays 1 until the clock edge that performs the table write of the last block.
- R2: A `trigger` seen while `busy` is 1 has no effect: no extra reads, no extra writes, and no second sweep after the current one.
- R3: In each sweep the blocks are visited in ascending order 0 to NUM_BLOCKS-1. Each block gets exactly one `tbl_wr_en` cycle, `blk_done` is high in that cycle only, and two write cycles are never adjacent.
- R4: Every read request carries the current block and page index PAGES_PER_BLOCK-1 (255 by default).
- R5: The first read of a block uses the code present in the table for that block when the sweep starts.
- R6: After the first read, the code is lowered by exactly 1 per read for as long as each new count is strictly lower than the best so far.
- R7: Once lowering stops, the next read is at best+1, and the code keeps rising by 1 while each count is strictly lower than the best so far.
- R8: An error count equal to the best so far ends the current direction and does not replace the held code.
- R9: No read is issued below code 0 or above code 255. At 0 the downward phase is skipped or ends, and at 255 the upward phase is skipped or ends.
- R10: `rd_req_valid` stays high with block, page and code stable until `rd_req_ready`. `rd_rsp_ready` is high only while a read is outstanding, and never together with `rd_req_valid`.
- R11: The table write for a block holds the code that produced the minimum error count among that block's reads, with the earliest such code kept on ties.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trigger | input | 1 | Sweep request, level sampled |
| busy | output | 1 | High for the duration of a sweep |
| blk_done | output | 1 | One-cycle pulse with each block's table write |
| rd_req_valid | output | 1 | Test read request valid |
| rd_req_ready | input | 1 | Test read request accepted |
| rd_req_block | output | BLK_W | Block to read |
| rd_req_page | output | PAGE_W | Page to read (always the last page) |
| rd_req_vref | output | VREF_W | Reference voltage code for the read |
| rd_rsp_valid | input | 1 | Error count valid |
| rd_rsp_ready | output | 1 | Engine is waiting for an error count |
| rd_rsp_errcnt | input | ERR_W | Error count of the read |
| tbl_rd_addr | output | BLK_W | Table read address (current block) |
| tbl_rd_data | input | VREF_W | Stored code for `tbl_rd_addr` |
| tbl_wr_en | output | 1 | Table write strobe |
| tbl_wr_addr | output | BLK_W | Table write address |
| tbl_wr_data | output | VREF_W | Learned code to store |

## Verification
The engine's internal state shows up on the request stream within one read. A wrong candidate code or a wrong search phase appears as a wrong `rd_req_vref` on the very next accepted request. A lost best code or best count appears as a wrong `tbl_wr_data` when the block closes, a few reads later. A block counter error shows as a wrong `rd_req_block` on the first request of the next block. A busy flag out of step shows up in the first cycle after the trigger or after the final write. For that reason the bench compares every accepted request, every write and the busy level against a behavioural model in every cycle, while the ready and valid inputs are throttled.

// File: rtl/rdv_calib_pkg.sv
package rdv_calib_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_REQ,
    ST_WAIT,
    ST_WRITE
  } calib_state_e;

  typedef enum logic [1:0] {
    PH_BASE,
    PH_DOWN,
    PH_UP
  } search_phase_e;

endpackage

// File: rtl/rdv_blk_iter.sv
module rdv_blk_iter #(
  parameter int NUM_BLOCKS = 8,
  parameter int BLK_W      = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             advance,
  output logic [BLK_W-1:0] blk,
  output logic             last,
  output logic             busy
);

  localparam logic [BLK_W-1:0] LAST_BLK = BLK_W'(NUM_BLOCKS - 1);

  assign last = (blk == LAST_BLK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      blk  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      blk  <= '0;
    end else if (advance) begin
      if (last) busy <= 1'b0;
      else      blk  <= blk + 1'b1;
    end
  end

endmodule

// File: rtl/rdv_best_keep.sv
module rdv_best_keep #(
  parameter int VREF_W = 8,
  parameter int ERR_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              offer,
  input  logic [VREF_W-1:0] cand_v,
  input  logic [ERR_W-1:0]  cand_e,
  output logic [VREF_W-1:0] best_v,
  output logic              improves
);

  logic [ERR_W-1:0] best_e;

  // strict compare: a tie keeps the code already held
  assign improves = (cand_e < best_e);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      best_v <= '0;
      best_e <= '1;
    end else if (load || (offer && improves)) begin
      best_v <= cand_v;
      best_e <= cand_e;
    end
  end

endmodule

// File: rtl/rdv_calib_engine.sv
module rdv_calib_engine
  import rdv_calib_pkg::*;
#(
  parameter int NUM_BLOCKS      = 8,
  parameter int PAGES_PER_BLOCK = 256,
  parameter int VREF_W          = 8,
  parameter int ERR_W           = 16,
  localparam int BLK_W  = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1,
  localparam int PAGE_W = (PAGES_PER_BLOCK > 1) ? $clog2(PAGES_PER_BLOCK) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trigger,
  output logic              busy,
  output logic              blk_done,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [BLK_W-1:0]  rd_req_block,
  output logic [PAGE_W-1:0] rd_req_page,
  output logic [VREF_W-1:0] rd_req_vref,
  input  logic              rd_rsp_valid,
  output logic              rd_rsp_ready,
  input  logic [ERR_W-1:0]  rd_rsp_errcnt,
  output logic [BLK_W-1:0]  tbl_rd_addr,
  input  logic [VREF_W-1:0] tbl_rd_data,
  output logic              tbl_wr_en,
  output logic [BLK_W-1:0]  tbl_wr_addr,
  output logic [VREF_W-1:0] tbl_wr_data
);

  localparam logic [PAGE_W-1:0] PROBE_PAGE = PAGE_W'(PAGES_PER_BLOCK - 1);
  localparam logic [VREF_W-1:0] VREF_MAX   = '1;

  calib_state_e     state;
  search_phase_e    phase;
  logic [VREF_W-1:0] cand_v;
  logic [VREF_W-1:0] best_v;
  logic [BLK_W-1:0]  blk;
  logic              last_blk;
  logic              improves;
  logic              start_sweep;
  logic              rsp_fire;

  assign start_sweep = (state == ST_IDLE) && trigger;
  assign rsp_fire    = (state == ST_WAIT) && rd_rsp_valid;

  rdv_blk_iter #(
    .NUM_BLOCKS(NUM_BLOCKS),
    .BLK_W     (BLK_W)
  ) u_iter (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start_sweep),
    .advance(state == ST_WRITE),
    .blk    (blk),
    .last   (last_blk),
    .busy   (busy)
  );

  rdv_best_keep #(
    .VREF_W(VREF_W),
    .ERR_W (ERR_W)
  ) u_best (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (rsp_fire && (phase == PH_BASE)),
    .offer   (rsp_fire && (phase != PH_BASE)),
    .cand_v  (cand_v),
    .cand_e  (rd_rsp_errcnt),
    .best_v  (best_v),
    .improves(improves)
  );

  assign rd_req_valid = (state == ST_REQ);
  assign rd_req_block = blk;
  assign rd_req_page  = PROBE_PAGE;
  assign rd_req_vref  = cand_v;
  assign rd_rsp_ready = (state == ST_WAIT);
  assign tbl_rd_addr  = blk;
  assign tbl_wr_en    = (state == ST_WRITE);
  assign blk_done     = (state == ST_WRITE);
  assign tbl_wr_addr  = blk;
  assign tbl_wr_data  = best_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      phase  <= PH_BASE;
      cand_v <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (trigger) state <= ST_LOAD;
        ST_LOAD: begin
          cand_v <= tbl_rd_data;
          phase  <= PH_BASE;
          state  <= ST_REQ;
        end
        ST_REQ: if (rd_req_ready) state <= ST_WAIT;
        ST_WAIT: if (rd_rsp_valid) begin
          unique case (phase)
            PH_BASE: begin
              if (cand_v != '0) begin
                cand_v <= cand_v - 1'b1;
                phase  <= PH_DOWN;
                state  <= ST_REQ;
              end else if (cand_v != VREF_MAX) begin
                cand_v <= cand_v + 1'b1;
                phase  <= PH_UP;
                state  <= ST_REQ;
              end else begin
                state <= ST_WRITE;
              end
            end
            PH_DOWN: begin
              if (improves && (cand_v != '0)) begin
                cand_v <= cand_v - 1'b1;
                state  <= ST_REQ;
              end else if (improves) begin
                cand_v <= cand_v + 1'b1;
                phase  <= PH_UP;
                state  <= ST_REQ;
              end else if (best_v != VREF_MAX) begin
                cand_v <= best_v + 1'b1;
                phase  <= PH_UP;
                state  <= ST_REQ;
              end else begin
                state <= ST_WRITE;
              end
            end
            default: begin
              if (improves && (cand_v != VREF_MAX)) begin
                cand_v <= cand_v + 1'b1;
                state  <= ST_REQ;
              end else begin
                state <= ST_WRITE;
              end
            end
          endcase
        end
        default: state <= last_blk ? ST_IDLE : ST_LOAD;
      endcase
    end
  end

endmodule

// File: rtl/rdv_calib_chk.sv
module rdv_calib_chk #(
  parameter int BLK_W  = 3,
  parameter int PAGE_W = 8,
  parameter int VREF_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              trigger,
  input logic              busy,
  input logic              blk_done,
  input logic              rd_req_valid,
  input logic              rd_req_ready,
  input logic [BLK_W-1:0]  rd_req_block,
  input logic [PAGE_W-1:0] rd_req_page,
  input logic [VREF_W-1:0] rd_req_vref,
  input logic              rd_rsp_ready,
  input logic              tbl_wr_en
);

  localparam logic [PAGE_W-1:0] LAST_PAGE = '1;

  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_vref) && $stable(rd_req_block));

  p_one_in_flight_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> !rd_rsp_ready);

  p_probe_page_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> rd_req_page == LAST_PAGE);

  p_write_in_sweep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_wr_en |-> busy && blk_done);

  p_write_spaced_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_wr_en |=> !tbl_wr_en);

  p_busy_from_trigger_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(trigger));

  p_busy_ends_on_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !tbl_wr_en |=> busy);

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rd_req_valid && !rd_rsp_ready && !tbl_wr_en);

endmodule

bind rdv_calib_engine rdv_calib_chk #(
  .BLK_W (BLK_W),
  .PAGE_W(PAGE_W),
  .VREF_W(VREF_W)
) u_calib_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .trigger     (trigger),
  .busy        (busy),
  .blk_done    (blk_done),
  .rd_req_valid(rd_req_valid),
  .rd_req_ready(rd_req_ready),
  .rd_req_block(rd_req_block),
  .rd_req_page (rd_req_page),
  .rd_req_vref (rd_req_vref),
  .rd_rsp_ready(rd_rsp_ready),
  .tbl_wr_en   (tbl_wr_en)
);

// File: tb/rdv_calib_engine_tb_top.sv
module rdv_calib_engine_tb_top;

  localparam int NB = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       trigger;
  logic       busy, blk_done;
  logic       rd_req_valid, rd_req_ready;
  logic [2:0] rd_req_block;
  logic [7:0] rd_req_page, rd_req_vref;
  logic       rd_rsp_valid, rd_rsp_ready;
  logic [15:0] rd_rsp_errcnt;
  logic [2:0] tbl_rd_addr;
  logic [7:0] tbl_rd_data;
  logic       tbl_wr_en;
  logic [2:0] tbl_wr_addr;
  logic [7:0] tbl_wr_data;

  always #5 clk = ~clk;

  logic [7:0] tbl [NB];
  int opt_v [NB];
  int flat_w [NB];

  assign tbl_rd_data = tbl[tbl_rd_addr];

  rdv_calib_engine dut_i (
    .clk(clk), .rst_n(rst_n), .trigger(trigger), .busy(busy), .blk_done(blk_done),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_block(rd_req_block),
    .rd_req_page(rd_req_page), .rd_req_vref(rd_req_vref), .rd_rsp_valid(rd_rsp_valid),
    .rd_rsp_ready(rd_rsp_ready), .rd_rsp_errcnt(rd_rsp_errcnt), .tbl_rd_addr(tbl_rd_addr),
    .tbl_rd_data(tbl_rd_data), .tbl_wr_en(tbl_wr_en), .tbl_wr_addr(tbl_wr_addr),
    .tbl_wr_data(tbl_wr_data)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit model_busy = 0;
  int writes_seen = 0;
  int exp_v[$];
  int exp_b[$];
  int exp_w[$];
  int rsp_q[$];

  function automatic int errf(int b, int v);
    int d;
    d = (v > opt_v[b]) ? v - opt_v[b] : opt_v[b] - v;
    return (d <= flat_w[b]) ? 20 + b : 20 + b + (d - flat_w[b]) * 3;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // behavioural search per block, from the table as it stands at the trigger
  task automatic plan_sweep();
    for (int b = 0; b < NB; b++) begin
      int best, be, v, c;
      best = tbl[b];
      be = errf(b, best);
      exp_v.push_back(best); exp_b.push_back(b);
      v = best;
      while (v > 0) begin
        c = v - 1;
        exp_v.push_back(c); exp_b.push_back(b);
        if (errf(b, c) < be) begin best = c; be = errf(b, c); v = c; end
        else break;
      end
      v = best;
      while (v < 255) begin
        c = v + 1;
        exp_v.push_back(c); exp_b.push_back(b);
        if (errf(b, c) < be) begin best = c; be = errf(b, c); v = c; end
        else break;
      end
      exp_w.push_back(best);
    end
  endtask

  task automatic tick(bit trig);
    bit nb;
    @(negedge clk);
    cyc++;
    trigger      = trig;
    rd_req_ready = (cyc % 3) != 1;
    rd_rsp_valid = (rsp_q.size() > 0) && ((cyc % 4) != 2);
    rd_rsp_errcnt = (rsp_q.size() > 0) ? 16'(rsp_q[0]) : 16'd0;
    #1;
    if (!rst_n) return;
    chk(busy == model_busy, "R1 busy level", busy, model_busy);
    nb = model_busy;
    if (trig && !model_busy) begin
      plan_sweep();
      nb = 1;
    end
    if (rd_req_valid) chk(!rd_rsp_ready, "R10 ready while requesting", rd_rsp_ready, 0);
    if (rd_req_valid && rd_req_ready) begin
      if (exp_v.size() == 0) begin
        chk(0, "R2 unexpected request", rd_req_vref, -1);
      end else begin
        int ev, eb;
        ev = exp_v.pop_front();
        eb = exp_b.pop_front();
        chk(rd_req_vref == ev, "R5 R6 R7 R8 R9 request code", rd_req_vref, ev);
        chk(rd_req_block == eb, "R3 request block", rd_req_block, eb);
        chk(rd_req_page == 8'd255, "R4 probe page", rd_req_page, 255);
      end
      rsp_q.push_back(errf(rd_req_block, rd_req_vref));
    end
    if (rd_rsp_valid && rd_rsp_ready) void'(rsp_q.pop_front());
    chk(blk_done == tbl_wr_en, "R3 done with write", blk_done, tbl_wr_en);
    if (tbl_wr_en) begin
      if (exp_w.size() == 0) begin
        chk(0, "R2 unexpected write", tbl_wr_addr, -1);
      end else begin
        int ew;
        ew = exp_w.pop_front();
        chk(tbl_wr_addr == writes_seen, "R3 write order", tbl_wr_addr, writes_seen);
        chk(tbl_wr_data == ew, "R11 learned code", tbl_wr_data, ew);
        chk(exp_b.size() == 0 || exp_b[0] != writes_seen, "R3 write before reads done",
            exp_b.size(), 0);
      end
      tbl[tbl_wr_addr] = tbl_wr_data;
      writes_seen++;
      if (writes_seen == NB) begin
        writes_seen = 0;
        nb = 0;
      end
    end
    model_busy = nb;
  endtask

  task automatic run_sweep(int extra_trig_at);
    int k;
    tick(1);
    k = 0;
    while (model_busy && cyc < 100000) begin
      tick(k == extra_trig_at);
      k++;
    end
    if (cyc >= 100000) chk(0, "R1 watchdog expired", cyc, 0);
  endtask

  initial begin
    int fin [NB];
    tbl[0] = 8'd100; opt_v[0] = 90;  flat_w[0] = 0;
    tbl[1] = 8'd50;  opt_v[1] = 60;  flat_w[1] = 0;
    tbl[2] = 8'd3;   opt_v[2] = 0;   flat_w[2] = 0;
    tbl[3] = 8'd252; opt_v[3] = 255; flat_w[3] = 0;
    tbl[4] = 8'd0;   opt_v[4] = 0;   flat_w[4] = 0;
    tbl[5] = 8'd255; opt_v[5] = 255; flat_w[5] = 0;
    tbl[6] = 8'd120; opt_v[6] = 120; flat_w[6] = 2;
    tbl[7] = 8'd40;  opt_v[7] = 30;  flat_w[7] = 2;
    fin = '{90, 60, 0, 255, 0, 255, 120, 32};
    rst_n = 1'b0;
    trigger = 1'b0;
    rd_req_ready = 1'b0;
    rd_rsp_valid = 1'b0;
    rd_rsp_errcnt = '0;
    repeat (3) tick(0);
    chk(busy == 0, "R1 reset busy", busy, 0);
    chk(rd_req_valid == 0, "R10 reset request", rd_req_valid, 0);
    chk(tbl_wr_en == 0, "R3 reset write", tbl_wr_en, 0);
    rst_n = 1'b1;
    repeat (4) tick(0);
    // first sweep with a stray trigger in the middle (R2)
    run_sweep(40);
    for (int b = 0; b < NB; b++)
      chk(tbl[b] == fin[b], "R8 R9 R11 table after sweep", tbl[b], fin[b]);
    repeat (30) tick(0);
    chk(exp_v.size() == 0 && exp_w.size() == 0, "R2 no extra sweep", exp_v.size(), 0);
    // second sweep re-starts from the learned codes (R5)
    run_sweep(-1);
    for (int b = 0; b < NB; b++)
      chk(tbl[b] == fin[b], "R5 R11 table stable", tbl[b], fin[b]);
    repeat (5) tick(0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule